// File: doc/BRIEF.md
# Interrupt Set-Enable Register Bank

This block keeps one forwarding-enable flag for every interrupt of a distributor-style interrupt controller and presents those flags to software as 32-bit words in a memory-mapped window. Software turns an interrupt on by writing a word in which that interrupt's bit is 1. A write of 0 to a bit does nothing. A companion disable path turns interrupts off through a per-interrupt clear strobe vector. The current flags go straight out to the downstream forwarding logic.

Every access carries a security attribute and the index of the requesting processor. Two configuration inputs decide what each requester may see and change: a per-interrupt group vector and an implemented-interrupt mask. Bits that a requester is not allowed to reach read as zero, and writes to them are ignored. The first word covers the private interrupts. It has a separate copy for each low-numbered processor. The sixteen software-generated interrupts in that word are fixed on.

Top module: `intr_enable_bank`

## Requirements
- R1: After a synchronous active-high reset, every stored enable is 0. `spi_en` is all zero, `priv_en` holds only the fixed software-generated bits, and `rd_valid` is 0.
- R2: Enable word n sits at byte offset 0x100 + 4*n, for n from 0 to NUM_WORDS-1. Interrupt m is held in word m/32, bit m%32. Address bits [1:0] are ignored.
- R3: When a 1 is written to an accessible bit, that interrupt is enabled. A later read of the bit returns 1 until the bit is cleared. Writing 0 leaves the bit unchanged. A read returns the current enable state.
- R4: When `rd_en` is high in cycle t, `rd_data` holds the word and `rd_valid` is 1 in cycle t+1. `rd_valid` is 0 after every cycle with no read. A write made in the same cycle as a read is not seen by that read.
- R5: A bit whose `impl_mask` bit is 0 reads as 0 and ignores writes.
- R6: When `sec_disable` is 0 and `req_secure` is 0, a bit whose `group_ns` bit is 0 (Group 0 or Secure Group 1) reads as 0 and ignores writes. A 1 in `group_ns` marks a Non-secure Group 1 interrupt.
- R7: Word 0 has a separate copy for each processor index below NUM_BANKS, and an access from index p reaches copy p only. For a processor index of NUM_BANKS or more, word 0 reads as 0 and ignores writes.
- R8: Bits 15:0 of word 0 are software-generated interrupts. Each one reads as 1 whenever it is implemented and accessible, and writes to it are ignored. These bits appear in every `priv_en` copy equal to `impl_mask[15:0]`.
- R9: A 1 in `clr_en[m]` clears enable m at the clock edge. For m below 32, the clear applies to the word-0 copy selected by `clr_pe`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: A read from an offset outside the enable words returns 0 with `rd_valid` set. A write to such an offset changes nothing.
- R11: `spi_en[j]` is the enable of interrupt 32+j. `priv_en[32*b+i]` is bit i of the word-0 copy for processor b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data, 1 = enable |
| req_secure | input | 1 | Access is Secure |
| req_pe | input | PE_W | Index of the requesting processor |
| sec_disable | input | 1 | Security filtering off when 1 |
| group_ns | input | NUM_WORDS*32 | 1 = interrupt is Non-secure Group 1 |
| impl_mask | input | NUM_WORDS*32 | 1 = interrupt is implemented |
| clr_en | input | NUM_WORDS*32 | Per-interrupt clear strobes |
| clr_pe | input | PE_W | Word-0 copy targeted by clr_en[31:0] |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data valid this cycle |
| spi_en | output | (NUM_WORDS-1)*32 | Enables of shared interrupts 32 and up |
| priv_en | output | NUM_BANKS*32 | Per-processor word-0 enables |

## Verification
Read data and `rd_valid` are due one clock edge after the read strobe. The stored enables and the `spi_en`/`priv_en` outputs change at the same edge as the write or clear that causes them. The bench drives each operation on a falling edge and samples all results on the next falling edge, so exactly one rising edge lies in between. The read value is predicted from the model state before the operation is applied, because a read does not see a write made in the same cycle. The model is updated only after that prediction, with the set taking precedence over any clear in the same cycle.

// File: rtl/ien_pkg.sv
package ien_pkg;
  localparam int          WORD_BITS = 32;
  localparam int          BASE_OFF  = 'h100;
  localparam logic [31:0] SGI_MASK  = 32'h0000_FFFF;

  // Bits a requester may reach in one word: implemented, and either
  // filtering is off, the access is Secure, or the interrupt is Non-secure.
  function automatic logic [31:0] access_bits(input logic [31:0] impl,
                                              input logic [31:0] grp_ns,
                                              input logic        sec_dis,
                                              input logic        secure);
    return impl & (grp_ns | {32{sec_dis | secure}});
  endfunction
endpackage

// File: rtl/ien_decode.sv
module ien_decode import ien_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 4,
  parameter int PE_W      = 4,
  parameter int NUM_BANKS = 8,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PE_W-1:0]   req_pe,
  output logic              word_hit,
  output logic [WIDX_W-1:0] word_idx,
  output logic              pe_ok,
  output logic [BANK_W-1:0] bank_idx
);
  logic [ADDR_W-1:0] off;

  assign off      = addr - ADDR_W'(BASE_OFF);
  assign word_hit = (addr >= ADDR_W'(BASE_OFF)) &&
                    (off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_WORDS));
  assign word_idx = off[WIDX_W+1:2];
  assign pe_ok    = req_pe < PE_W'(NUM_BANKS);
  assign bank_idx = req_pe[BANK_W-1:0];
endmodule

// File: rtl/ien_word.sv
module ien_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_bits) | set_bits;
  end

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((q & $past(set_bits)) == $past(set_bits)));

  assert_clear_wins_unless_set_R9: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((q & $past(clr_bits) & ~$past(set_bits)) == '0));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    ((set_bits == '0) && (clr_bits == '0)) |=> $stable(q));
endmodule

// File: rtl/intr_enable_bank.sv
module intr_enable_bank import ien_pkg::*; #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_BANKS = 8,
  parameter int PE_W      = 4,
  parameter int ADDR_W    = 12,
  localparam int NUM_INTR = NUM_WORDS * WORD_BITS,
  localparam int SPI_W    = NUM_INTR - WORD_BITS,
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  input  logic                       req_secure,
  input  logic [PE_W-1:0]            req_pe,
  input  logic                       sec_disable,
  input  logic [NUM_INTR-1:0]        group_ns,
  input  logic [NUM_INTR-1:0]        impl_mask,
  input  logic [NUM_INTR-1:0]        clr_en,
  input  logic [PE_W-1:0]            clr_pe,
  output logic [31:0]                rd_data,
  output logic                       rd_valid,
  output logic [SPI_W-1:0]           spi_en,
  output logic [NUM_BANKS*32-1:0]    priv_en
);
  // ---------------- decode ----------------
  logic              word_hit;
  logic [WIDX_W-1:0] word_idx;
  logic              pe_ok;
  logic [BANK_W-1:0] bank_idx;

  ien_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .PE_W(PE_W),
               .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(addr), .req_pe(req_pe), .word_hit(word_hit),
    .word_idx(word_idx), .pe_ok(pe_ok), .bank_idx(bank_idx));

  // ---------------- per-word configuration ----------------
  logic [31:0] impl_w [NUM_WORDS];
  logic [31:0] grp_w  [NUM_WORDS];
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_cfg
    assign impl_w[w] = impl_mask[w*32 +: 32];
    assign grp_w[w]  = group_ns[w*32 +: 32];
  end

  logic        is_w0;
  logic [31:0] rd_mask;   // bits the current requester may see
  logic [31:0] wr_mask;   // bits the current requester may set

  assign is_w0   = (word_idx == '0);
  assign rd_mask = word_hit
                 ? (access_bits(impl_w[word_idx], grp_w[word_idx], sec_disable, req_secure)
                    & {32{!is_w0 || pe_ok}})
                 : 32'h0;
  assign wr_mask = rd_mask & ~(is_w0 ? SGI_MASK : 32'h0);

  // ---------------- shared words (1 .. NUM_WORDS-1) ----------------
  logic [31:0] shr_q [NUM_WORDS-1];
  for (genvar j = 1; j < NUM_WORDS; j++) begin : g_shr
    logic [31:0] set_v;
    assign set_v = (wr_en && (word_idx == WIDX_W'(j))) ? (wdata & wr_mask) : 32'h0;
    ien_word #(.W(32)) u_w (
      .clk(clk), .rst(rst), .set_bits(set_v),
      .clr_bits(clr_en[j*32 +: 32]), .q(shr_q[j-1]));
    assign spi_en[(j-1)*32 +: 32] = shr_q[j-1];
  end

  // ---------------- banked word 0 ----------------
  logic [31:0] bank_q [NUM_BANKS];
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [31:0] set_v;
    logic [31:0] clr_v;
    assign set_v = (wr_en && is_w0 && (bank_idx == BANK_W'(b))) ? (wdata & wr_mask) : 32'h0;
    assign clr_v = (clr_pe == PE_W'(b)) ? (clr_en[31:0] & ~SGI_MASK) : 32'h0;
    ien_word #(.W(32)) u_w (
      .clk(clk), .rst(rst), .set_bits(set_v), .clr_bits(clr_v), .q(bank_q[b]));
    assign priv_en[b*32 +: 32] = bank_q[b] | (impl_mask[31:0] & SGI_MASK);
  end

  // ---------------- read path ----------------
  logic [31:0] sel_store;
  logic [31:0] rd_value;

  assign sel_store = is_w0 ? (bank_q[bank_idx] | SGI_MASK) : shr_q[word_idx - WIDX_W'(1)];
  assign rd_value  = sel_store & rd_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_value;
    end
  end

  assert_rd_valid_next_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_no_valid_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_oob_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !word_hit) |=> (rd_data == 32'h0));

  assert_masked_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ((rd_data & ~$past(rd_mask)) == 32'h0));
endmodule

// File: tb/sim_intr_enable_bank.sv
`timescale 1ns/1ps
module sim_intr_enable_bank;
  localparam int NW = 4, NB = 8, PW = 4, AW = 12, NI = NW*32;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, req_secure = 0, sec_disable = 1;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [PW-1:0] req_pe = '0, clr_pe = '0;
  logic [NI-1:0] group_ns = '0, impl_mask = '0, clr_en = '0;
  logic [31:0] rd_data;
  logic rd_valid;
  logic [NI-33:0] spi_en;
  logic [NB*32-1:0] priv_en;

  int checks = 0, errors = 0;

  // bench model
  logic [NI-1:0] m_shr = '0;
  logic [31:0]   m_bank [NB];

  always #2 clk = ~clk;   // 250 MHz

  intr_enable_bank #(.NUM_WORDS(NW), .NUM_BANKS(NB), .PE_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .req_secure(req_secure), .req_pe(req_pe), .sec_disable(sec_disable),
    .group_ns(group_ns), .impl_mask(impl_mask), .clr_en(clr_en), .clr_pe(clr_pe),
    .rd_data(rd_data), .rd_valid(rd_valid), .spi_en(spi_en), .priv_en(priv_en));

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // word index for a byte offset, -1 when outside the window
  function automatic int word_of(input int a);
    int w = (a - 'h100) / 4;
    if (a < 'h100 || w >= NW) return -1;
    return w;
  endfunction

  function automatic bit visible(input int m, input bit sec, input int pe);
    if (!impl_mask[m]) return 0;
    if (!(sec_disable || sec || group_ns[m])) return 0;
    if (m < 32 && pe >= NB) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] exp_read(input int a, input bit sec, input int pe);
    logic [31:0] r = '0;
    int w = word_of(a);
    if (w < 0) return r;
    for (int i = 0; i < 32; i++) begin
      int m = w*32 + i;
      if (!visible(m, sec, pe)) r[i] = 0;
      else if (m < 16) r[i] = 1;
      else if (w == 0) r[i] = m_bank[pe][i];
      else r[i] = m_shr[m];
    end
    return r;
  endfunction

  function automatic logic [NB*32-1:0] exp_priv();
    logic [NB*32-1:0] p;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 32; i++)
        p[b*32+i] = (i < 16) ? impl_mask[i] : m_bank[b][i];
    return p;
  endfunction

  task automatic do_op(input string tag, input bit wr, input bit rd, input int a,
                       input logic [31:0] d, input bit sec, input int pe,
                       input logic [NI-1:0] clr, input int cpe);
    logic [31:0] er;
    logic [NI-1:0] setv = '0;
    int w;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = AW'(a); wdata = d; req_secure = sec;
    req_pe = PW'(pe); clr_en = clr; clr_pe = PW'(cpe);
    er = exp_read(a, sec, pe);
    w = word_of(a);
    if (wr && w >= 0)
      for (int i = 0; i < 32; i++)
        if (d[i] && visible(w*32+i, sec, pe) && (w*32+i) >= 16) setv[w*32+i] = 1;
    // clears first, set wins
    for (int m = 0; m < NI; m++) begin
      if (m < 32) begin
        if (clr[m] && m >= 16 && cpe < NB && !(setv[m] && pe == cpe)) m_bank[cpe][m] = 0;
        if (setv[m]) m_bank[pe][m] = 1;
      end else begin
        if (clr[m] && !setv[m]) m_shr[m] = 0;
        if (setv[m]) m_shr[m] = 1;
      end
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; clr_en = '0;
    chk({tag, " R4 valid"}, 256'(rd_valid), 256'(rd));
    if (rd) chk({tag, " rdata"}, 256'(rd_data), 256'(er));
    chk("R11 spi_en", 256'(spi_en), 256'(m_shr[NI-1:32]));
    chk("R11 priv_en", 256'(priv_en), 256'(exp_priv()));
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) m_bank[b] = '0;
    impl_mask = {NI{1'b1}};
    impl_mask[NI-1 -: 20] = '0;      // top interrupts not implemented
    impl_mask[50] = 0; impl_mask[3] = 0; impl_mask[20] = 0;
    for (int m = 0; m < NI; m++) group_ns[m] = $urandom % 2;
    group_ns[40] = 1; group_ns[41] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 spi_en", 256'(spi_en), 256'(0));
    chk("R1 priv_en", 256'(priv_en), 256'(exp_priv()));
    chk("R1 rd_valid", 256'(rd_valid), 256'(0));

    // R2: interrupt 40 -> word 1 bit 8
    do_op("R2 set40", 1, 0, 'h104, 32'h100, 1, 0, '0, 0);
    do_op("R2 read word1", 0, 1, 'h104, 0, 1, 0, '0, 0);
    chk("R2 bit40", 256'(spi_en[8]), 256'(1));
    // R3 write 0 no effect
    do_op("R3 zero write", 1, 1, 'h104, 32'h0, 1, 0, '0, 0);
    do_op("R3 readback", 0, 1, 'h106, 0, 1, 0, '0, 0);
    // R5 unimplemented 50 and top word
    do_op("R5 write", 1, 0, 'h104, 32'h40000, 1, 0, '0, 0);
    do_op("R5 write top", 1, 1, 'h10C, 32'hFFFF_FFFF, 1, 0, '0, 0);
    do_op("R5 read", 0, 1, 'h104, 0, 1, 0, '0, 0);
    // R6 security filter
    sec_disable = 0;
    do_op("R6 ns write41", 1, 0, 'h104, 32'h200, 0, 0, '0, 0);
    do_op("R6 ns read", 0, 1, 'h104, 0, 0, 0, '0, 0);
    do_op("R6 s read", 0, 1, 'h104, 0, 1, 0, '0, 0);
    // R7 banking
    do_op("R7 pe2 set", 1, 0, 'h100, 32'hFFFF_0000, 1, 2, '0, 0);
    do_op("R7 pe3 read", 0, 1, 'h100, 0, 1, 3, '0, 0);
    do_op("R7 pe2 read", 0, 1, 'h100, 0, 1, 2, '0, 0);
    do_op("R7 pe9 write", 1, 1, 'h100, 32'hFFFF_FFFF, 1, 9, '0, 0);
    // R8 SGI bits
    do_op("R8 sgi write", 1, 1, 'h100, 32'h0000_FFFF, 1, 5, '0, 0);
    // R9 clear and set-wins
    do_op("R9 clear pe2", 0, 0, 'h100, 0, 1, 0, NI'(32'h0F00_0000), 2);
    do_op("R9 set vs clr", 1, 0, 'h108, 32'h1, 1, 0, NI'(1) << 64, 0);
    do_op("R9 read", 0, 1, 'h108, 0, 1, 0, '0, 0);
    // R10 out of window
    do_op("R10 low", 1, 1, 'h0FC, 32'hFFFF_FFFF, 1, 0, '0, 0);
    do_op("R10 high", 1, 1, 'h110, 32'hFFFF_FFFF, 1, 0, '0, 0);
    // R4 read sees old value on same-cycle write
    do_op("R4 rw same", 1, 1, 'h108, 32'h8000_0000, 1, 0, '0, 0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int a, pe, cpe;
      logic [NI-1:0] c;
      if (k % 150 == 0) sec_disable = $urandom % 2;
      a = 'h0F8 + 4 * ($urandom % (NW + 3)) + ($urandom % 4);
      pe = $urandom % 11;
      cpe = $urandom % 10;
      c = '0;
      if ($urandom % 4 == 0)
        for (int m = 0; m < NI; m++) c[m] = ($urandom % 8 == 0);
      do_op("R3 random", $urandom % 2, $urandom % 2, a, $urandom, $urandom % 2, pe, c, cpe);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule